// File: doc/BRIEF.md
# SD SPI Command Framer and R1 Waiter

This block runs one SD card command transaction in SPI mode on top of a byte-wide transfer engine. A request carries a 6-bit command index and a 32-bit argument. The block lowers chip select and spends one filler byte slot. It then sends the six command bytes: a start byte that holds the index, the argument from its top byte down, and a checksum byte. After that it clocks filler bytes until the card answers with a byte whose top bit is clear. That byte is the R1 status. Its bits report idle (bit 0), erase reset (1), illegal command (2), command checksum error (3), erase sequence error (4), address error (5) and parameter error (6).

The wait for R1 is bounded by a poll count. When the limit runs out, the block reports a timeout with an all-ones status. The interface-condition command (index 8) and the read-operating-conditions command (index 58) return four extra bytes, which the block captures. With the keep-select option, chip select stays low after a good answer, so a data-block transfer can follow on the same selection. Otherwise the block raises chip select and clocks one more filler byte. The byte engine sees a level request `spi_req_o` with the byte to send. It answers with a one-cycle `spi_done_i` and the byte it received.

Top module: `sd_cmd_framer`

## Requirements
- R1: After an accepted start, the first byte transferred is 0xFF with chip select low. The next five bytes are 0x40 OR the command index, then argument bits 31:24, 23:16, 15:8 and 7:0. Chip select stays low throughout.
- R2: The seventh byte of the transaction, the checksum byte, is 0x87 when the command index is 8 and 0x95 for every other index.
- R3: After the frame, the block sends 0xFF for each poll. Received bytes with bit 7 set are skipped, and bytes received during the frame are never taken as a reply. The first poll byte with bit 7 clear is returned on `r1_o`, with `timeout_o` low.
- R4: If TIMEOUT_POLLS polls all return bit 7 set, the transaction ends with `timeout_o` high and `r1_o` = 0xFF. A reply on poll number TIMEOUT_POLLS is still a valid reply.
- R5: For index 8 or 58, a valid R1 is followed by exactly four more 0xFF transfers. The received bytes form `tail_o`, first byte in bits 31:24. For other indices, or on timeout, no extra transfers occur and `tail_o` is 0.
- R6: Without keep-select, after the last reply byte chip select goes high, one 0xFF byte is transferred with chip select high, and chip select stays high after `done_o`.
- R7: With `keep_sel_i` high at start and a valid R1, no release byte is sent and chip select stays low after `done_o`. On timeout the release of R6 still happens.
- R8: `busy_o` is high from the cycle after an accepted start until the end of the transaction. `done_o` pulses for one cycle with `busy_o` low. A start while busy is ignored and does not queue.
- R9: In reset, chip select is high and `busy_o`, `done_o` and `spi_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transaction when idle |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | ARG_W | Command argument |
| keep_sel_i | input | 1 | Hold chip select low after a valid reply |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| r1_o | output | 8 | R1 status, 0xFF on timeout |
| timeout_o | output | 1 | No reply within the poll limit |
| tail_o | output | 8*TAIL_BYTES | Trailing reply bytes, first byte most significant |
| spi_req_o | output | 1 | Byte transfer request, held until done |
| spi_tx_o | output | 8 | Byte to send |
| spi_rx_i | input | 8 | Byte received, valid with spi_done_i |
| spi_done_i | input | 1 | Byte transfer complete |
| spi_cs_no | output | 1 | Card chip select, active low |

## Verification
A valid reply and timeout expiry can fall on the same byte completion: the last permitted poll. The bench provokes this by placing the reply on poll TIMEOUT_POLLS and, separately, by delaying it one poll past that. It judges the outcome from the reported status, the timeout flag, the exact byte count and the chip select level on every logged byte. It also sweeps all 64 command indices with varying reply delays, transfer latencies and keep-select settings.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_FRAME, ST_POLL, ST_TAIL, ST_TRAIL
  } sd_state_e;

  localparam logic [7:0] FILL_BYTE   = 8'hFF;
  localparam logic [7:0] START_MARK  = 8'h40;
  localparam logic [7:0] CRC_FIXED   = 8'h95;
  localparam logic [7:0] CRC_IFCOND  = 8'h87;
  localparam logic [7:0] R1_NONE     = 8'hFF;
  localparam logic [5:0] IDX_IFCOND  = 6'd8;
  localparam logic [5:0] IDX_RDOCR   = 6'd58;

  function automatic logic [7:0] crc_for(input logic [5:0] idx);
    return (idx == IDX_IFCOND) ? CRC_IFCOND : CRC_FIXED;
  endfunction

  function automatic logic has_tail(input logic [5:0] idx);
    return (idx == IDX_IFCOND) || (idx == IDX_RDOCR);
  endfunction
endpackage

// File: rtl/sd_frame_gen.sv
module sd_frame_gen
  import sd_cmd_pkg::*;
#(
  parameter int unsigned ARG_W = 32,
  parameter int unsigned SEL_W = 3
) (
  input  logic [5:0]       cmd_idx_i,
  input  logic [ARG_W-1:0] cmd_arg_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [7:0]       byte_o
);
  localparam int unsigned ARG_BYTES   = ARG_W / 8;
  localparam int unsigned FRAME_BYTES = ARG_BYTES + 2;

  logic [7:0] frame [FRAME_BYTES];

  assign frame[0] = START_MARK | {2'b00, cmd_idx_i};
  for (genvar g = 0; g < ARG_BYTES; g++) begin : g_arg
    assign frame[g+1] = cmd_arg_i[8*(ARG_BYTES-1-g) +: 8];
  end
  assign frame[FRAME_BYTES-1] = crc_for(cmd_idx_i);

  always_comb begin
    byte_o = FILL_BYTE;
    for (int i = 0; i < FRAME_BYTES; i++) begin
      if (sel_i == SEL_W'(i)) byte_o = frame[i];
    end
  end
endmodule

// File: rtl/sd_poll_timer.sv
module sd_poll_timer #(
  parameter int unsigned LIMIT = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic last_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(LIMIT - 1));

  assert_poll_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(LIMIT));
endmodule

// File: rtl/sd_tail_shift.sv
module sd_tail_shift #(
  parameter int unsigned TAIL_BYTES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    shift_i,
  input  logic [7:0]              rx_i,
  output logic [8*TAIL_BYTES-1:0] data_o
);
  logic [8*TAIL_BYTES-1:0] data_q;

  generate
    if (TAIL_BYTES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      data_q <= '0;
        else if (clear_i) data_q <= '0;
        else if (shift_i) data_q <= rx_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      data_q <= '0;
        else if (clear_i) data_q <= '0;
        else if (shift_i) data_q <= {data_q[8*TAIL_BYTES-9:0], rx_i};
      end
    end
  endgenerate

  assign data_o = data_q;
endmodule

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer
  import sd_cmd_pkg::*;
#(
  parameter int unsigned ARG_W         = 32,
  parameter int unsigned TIMEOUT_POLLS = 5000,
  parameter int unsigned TAIL_BYTES    = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [5:0]              cmd_idx_i,
  input  logic [ARG_W-1:0]        cmd_arg_i,
  input  logic                    keep_sel_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [7:0]              r1_o,
  output logic                    timeout_o,
  output logic [8*TAIL_BYTES-1:0] tail_o,
  output logic                    spi_req_o,
  output logic [7:0]              spi_tx_o,
  input  logic [7:0]              spi_rx_i,
  input  logic                    spi_done_i,
  output logic                    spi_cs_no
);
  localparam int unsigned FRAME_BYTES = ARG_W / 8 + 2;
  localparam int unsigned SEQ_MAX     = (FRAME_BYTES > TAIL_BYTES) ? FRAME_BYTES : TAIL_BYTES;
  localparam int unsigned SEQ_W       = (SEQ_MAX > 1) ? $clog2(SEQ_MAX) : 1;
  localparam logic [SEQ_W-1:0] FRAME_LAST = SEQ_W'(FRAME_BYTES - 1);
  localparam logic [SEQ_W-1:0] TAIL_LAST  = SEQ_W'(TAIL_BYTES - 1);

  sd_state_e        state_q;
  logic [5:0]       idx_q;
  logic [ARG_W-1:0] arg_q;
  logic             keep_q;
  logic [SEQ_W-1:0] seq_q;
  logic             cs_q, done_q, timeout_q;
  logic [7:0]       r1_q;
  logic [7:0]       frame_byte;
  logic             poll_last, got_reply, accept;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign got_reply = !spi_rx_i[7];

  sd_frame_gen #(.ARG_W(ARG_W), .SEL_W(SEQ_W)) frame_i (
    .cmd_idx_i (idx_q),
    .cmd_arg_i (arg_q),
    .sel_i     (seq_q),
    .byte_o    (frame_byte)
  );

  sd_poll_timer #(.LIMIT(TIMEOUT_POLLS)) timer_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (state_q == ST_IDLE),
    .step_i  ((state_q == ST_POLL) && spi_done_i && !got_reply && !poll_last),
    .last_o  (poll_last)
  );

  sd_tail_shift #(.TAIL_BYTES(TAIL_BYTES)) tail_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .shift_i ((state_q == ST_TAIL) && spi_done_i),
    .rx_i    (spi_rx_i),
    .data_o  (tail_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      arg_q     <= '0;
      keep_q    <= 1'b0;
      seq_q     <= '0;
      cs_q      <= 1'b1;
      done_q    <= 1'b0;
      timeout_q <= 1'b0;
      r1_q      <= R1_NONE;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          idx_q     <= cmd_idx_i;
          arg_q     <= cmd_arg_i;
          keep_q    <= keep_sel_i;
          cs_q      <= 1'b0;
          timeout_q <= 1'b0;
          r1_q      <= R1_NONE;
          state_q   <= ST_LEAD;
        end
        ST_LEAD: if (spi_done_i) begin
          seq_q   <= '0;
          state_q <= ST_FRAME;
        end
        ST_FRAME: if (spi_done_i) begin
          if (seq_q == FRAME_LAST) state_q <= ST_POLL;
          else                     seq_q   <= seq_q + 1'b1;
        end
        ST_POLL: if (spi_done_i) begin
          if (got_reply) begin
            r1_q <= spi_rx_i;
            if (has_tail(idx_q)) begin
              seq_q   <= '0;
              state_q <= ST_TAIL;
            end else if (keep_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              cs_q    <= 1'b1;
              state_q <= ST_TRAIL;
            end
          end else if (poll_last) begin
            r1_q      <= R1_NONE;
            timeout_q <= 1'b1;
            cs_q      <= 1'b1;
            state_q   <= ST_TRAIL;
          end
        end
        ST_TAIL: if (spi_done_i) begin
          if (seq_q == TAIL_LAST) begin
            if (keep_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              cs_q    <= 1'b1;
              state_q <= ST_TRAIL;
            end
          end else begin
            seq_q <= seq_q + 1'b1;
          end
        end
        ST_TRAIL: if (spi_done_i) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign r1_o      = r1_q;
  assign timeout_o = timeout_q;
  assign spi_req_o = (state_q != ST_IDLE);
  assign spi_tx_o  = (state_q == ST_FRAME) ? frame_byte : FILL_BYTE;
  assign spi_cs_no = cs_q;

  assert_cs_low_frame_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FRAME || state_q == ST_LEAD) |-> !spi_cs_no);
  assert_start_marker_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FRAME && seq_q == '0) |-> spi_tx_o[7:6] == 2'b01);
  assert_crc_end_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FRAME && seq_q == FRAME_LAST) |-> spi_tx_o[0]);
  assert_reply_msb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !timeout_o) |-> !r1_o[7]);
  assert_timeout_ones_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && timeout_o) |-> r1_o == R1_NONE);
  assert_release_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TRAIL) |-> spi_cs_no);
  assert_keep_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && keep_q && !timeout_o) |-> !spi_cs_no);
  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_busy_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(idx_q) && $stable(arg_q));
endmodule

// File: tb/sd_cmd_framer_tb.sv
module sd_cmd_framer_tb_top;
  localparam int LIMIT = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  cmd_idx_i = '0;
  logic [31:0] cmd_arg_i = '0;
  logic        keep_sel_i = 1'b0;
  logic        busy_o, done_o, timeout_o, spi_req_o, spi_cs_no;
  logic [7:0]  r1_o, spi_tx_o;
  logic [31:0] tail_o;
  logic [7:0]  spi_rx_i = 8'hFF;
  logic        spi_done_i = 1'b0;

  always #2 clk_i = ~clk_i;

  sd_cmd_framer #(.ARG_W(32), .TIMEOUT_POLLS(LIMIT), .TAIL_BYTES(4)) dut_i (
    .clk_i, .rst_ni, .start_i, .cmd_idx_i, .cmd_arg_i, .keep_sel_i,
    .busy_o, .done_o, .r1_o, .timeout_o, .tail_o,
    .spi_req_o, .spi_tx_o, .spi_rx_i, .spi_done_i, .spi_cs_no
  );

  int checks = 0;
  int fails  = 0;

  logic [7:0] tx_log [64];
  logic       cs_log [64];
  int         nlog = 0;
  int         sc_busy = 0;
  logic [7:0] sc_r1 = 8'h00;
  logic [31:0] sc_tail = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] resp_for(input int k);
    int p;
    if (k < 7) return 8'h00;          // bit 7 clear during frame: must not be taken
    p = k - 7;
    if (p < sc_busy) return 8'hFF;
    if (p == sc_busy) return sc_r1;
    if (p <= sc_busy + 4) return sc_tail[31 - 8*(p - sc_busy - 1) -: 8];
    return 8'hFF;
  endfunction

  // byte engine model
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk_i);
      spi_done_i = 1'b0;
      if (spi_req_o) begin
        if (wait_cnt < (nlog % 3)) wait_cnt++;
        else begin
          wait_cnt = 0;
          if (nlog < 64) begin
            tx_log[nlog] = spi_tx_o;
            cs_log[nlog] = spi_cs_no;
          end
          spi_rx_i   = resp_for(nlog);
          nlog++;
          spi_done_i = 1'b1;
        end
      end
    end
  end

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit keep,
                         input int nb, input logic [7:0] r1, input logic [31:0] tl, input bit inj);
    bit to, rel, seen;
    int polls, tn, total;
    logic [7:0] exp_b;
    int bad;
    sc_busy = nb; sc_r1 = r1; sc_tail = tl;
    nlog = 0;
    @(negedge clk_i);
    start_i = 1'b1; cmd_idx_i = idx; cmd_arg_i = arg; keep_sel_i = keep;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
    seen = 0;
    for (int n = 0; n < 3000 && !seen; n++) begin
      @(negedge clk_i);
      if (inj && n == 4) begin
        chk(busy_o == 1'b1, "R8 busy at mid start", busy_o, 1);
        start_i = 1'b1; cmd_idx_i = ~idx; cmd_arg_i = ~arg; keep_sel_i = ~keep;
      end else start_i = 1'b0;
      if (done_o) seen = 1;
    end
    start_i = 1'b0;
    chk(seen, "R8 done seen", seen, 1);
    to    = (nb >= LIMIT);
    polls = to ? LIMIT : nb + 1;
    tn    = (!to && (idx == 6'd8 || idx == 6'd58)) ? 4 : 0;
    rel   = to || !keep;
    total = 7 + polls + tn + (rel ? 1 : 0);
    chk(busy_o == 1'b0, "R8 idle at done", busy_o, 0);
    chk(timeout_o == to, "R4 timeout flag", timeout_o, to);
    chk(r1_o == (to ? 8'hFF : r1), "R3 R4 status", r1_o, to ? 8'hFF : r1);
    chk(tail_o == (tn != 0 ? tl : 32'h0), "R5 tail", tail_o, tn != 0 ? tl : 32'h0);
    chk(spi_cs_no == rel, "R6 R7 cs after done", spi_cs_no, rel);
    chk(nlog == total, "R4 R5 R6 byte count", nlog, total);
    chk(tx_log[0] == 8'hFF && cs_log[0] == 1'b0, "R1 lead byte", {cs_log[0], tx_log[0]}, 9'h0FF);
    chk(tx_log[1] == (8'h40 | {2'b00, idx}), "R1 start byte", tx_log[1], 8'h40 | {2'b00, idx});
    for (int j = 0; j < 4; j++)
      chk(tx_log[2+j] == arg[31-8*j -: 8], "R1 argument byte", tx_log[2+j], arg[31-8*j -: 8]);
    exp_b = (idx == 6'd8) ? 8'h87 : 8'h95;
    chk(tx_log[6] == exp_b, "R2 checksum byte", tx_log[6], exp_b);
    bad = -1;
    for (int k = 7; k < total && k < 64; k++) begin
      if (tx_log[k] != 8'hFF) bad = k;
      if (cs_log[k] != ((rel && k == total - 1) ? 1'b1 : 1'b0)) bad = k;
    end
    chk(bad < 0, "R3 R6 poll/tail/release bytes", bad, 32'hFFFFFFFF);
    for (int k = 1; k < 7; k++)
      chk(cs_log[k] == 1'b0, "R1 cs low in frame", cs_log[k], 0);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
    @(negedge clk_i);
    chk(spi_req_o == 1'b0 && busy_o == 1'b0, "R8 no queued start", {busy_o, spi_req_o}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(spi_cs_no == 1'b1, "R9 cs in reset", spi_cs_no, 1);
    chk(busy_o == 1'b0 && done_o == 1'b0 && spi_req_o == 1'b0, "R9 idle in reset",
        {busy_o, done_o, spi_req_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(spi_cs_no == 1'b1 && spi_req_o == 1'b0, "R9 idle after reset", {spi_cs_no, spi_req_o}, 2);

    // sweep every index
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a;
      a = 32'h9E3779B9 * (i + 1);
      run_cmd(6'(i), a, (i % 4) == 3, i % 5, 8'((i * 13) & 8'h7F), a ^ 32'hA55A3CC3, 1'b0);
    end
    // interface-condition frame, with keep and tail
    run_cmd(6'd8, 32'h000001AA, 1'b0, 2, 8'h01, 32'h000001AA, 1'b0);
    run_cmd(6'd8, 32'h000001AA, 1'b1, 0, 8'h05, 32'h12345678, 1'b0);
    // reply on the last allowed poll vs one too late
    run_cmd(6'd17, 32'h00000200, 1'b0, LIMIT - 1, 8'h00, 32'h0, 1'b0);
    run_cmd(6'd17, 32'h00000200, 1'b1, LIMIT - 1, 8'h00, 32'h0, 1'b0);
    run_cmd(6'd17, 32'h00000200, 1'b0, LIMIT, 8'h00, 32'h0, 1'b0);
    run_cmd(6'd17, 32'h00000200, 1'b1, LIMIT, 8'h00, 32'h0, 1'b0);
    run_cmd(6'd58, 32'h0, 1'b0, LIMIT, 8'h01, 32'hC0FF8000, 1'b0);
    run_cmd(6'd58, 32'h0, 1'b0, LIMIT - 1, 8'h01, 32'hC0FF8000, 1'b0);
    // start while busy
    run_cmd(6'd24, 32'hDEADBEEF, 1'b0, 3, 8'h00, 32'h0, 1'b1);
    run_cmd(6'd0, 32'h0, 1'b1, 1, 8'h01, 32'h0, 1'b1);
    // normal command after keep-select: release restored
    run_cmd(6'd55, 32'h0, 1'b0, 0, 8'h01, 32'h0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule